// File: doc/BRIEF.md
# Four-Lane Floating-Point Min/Max Reduction

The block takes four binary32 values, presented together as one vector, and reduces them to a single minimum or maximum. It is built as a two-level tree of scalar min/max stages. The first level combines lanes 0 and 1, and separately lanes 2 and 3. The second level combines the two partial results. A register between the levels can be kept or removed with a parameter. With the register kept, the result and the done strobe appear one cycle after the valid strobe. Without it, they appear in the same cycle.

Two NaN policies are offered.

- **Pairwise mode.** Each stage follows the older scalar rule. A quiet NaN is treated as missing data, and a signaling NaN is turned into a quiet NaN. Because the next stage then treats that quiet NaN as missing data, the answer can depend on which lane carried the signaling NaN.
- **Associative mode.** Every kind of NaN is treated as missing data, at every stage. Numbers therefore always win, and the outcome does not depend on lane order.

In both modes, the invalid flag reports any signaling NaN found in the vector.

Top module: `vec_minmax_reduce`

## Requirements
- R1: Lane k of `vecIn` is bits [32k+31:32k]. `selMax`=1 selects maximum and 0 selects minimum. `assocMode`=1 selects associative mode and 0 selects pairwise mode. The first level pairs lanes (0,1) and (2,3), and the second level combines the two partial results.
- R2: When no lane is a NaN, the result is the largest lane (maximum) or the smallest lane (minimum), in either mode.
- R3: Negative zero orders below positive zero. The maximum of a mix of +0 and -0 is 0x00000000, and the minimum is 0x80000000.
- R4: In pairwise mode, a stage that pairs a number with a signaling NaN outputs that NaN with bit 22 set. A stage that pairs a number with a quiet NaN outputs the number. For example, the maximum of lanes [1,2,3,sNaN] gives 0x40000000.
- R5: In associative mode, any NaN paired with a number is dropped. The result is therefore the minimum or maximum of the numeric lanes whenever at least one lane is numeric. For example, the maximum of [1,2,3,sNaN] gives 0x40400000, and the minimum of [3,2,1,sNaN] gives 0x3F800000.
- R6: When both operands of a stage are NaN, each is first quieted (bit 22 set). The stage then outputs the quieted value with the larger order key for maximum, or the smaller key for minimum. The order key is ~x when bit 31 is set, and x|0x80000000 otherwise. Every NaN result has bit 22 set.
- R7: `invalidOut` is 1 exactly when at least one lane is a signaling NaN, in both modes. A signaling NaN has exponent bits all ones, a nonzero mantissa and bit 22 clear.
- R8: In associative mode, `resOut` and `invalidOut` are the same for all 24 orderings of the four lanes.
- R9: With the default `PIPE`=1, `doneOut` is 1 exactly in the cycle after a cycle with `inValid`=1, and carries that vector's result. With `PIPE`=0, `doneOut` equals `inValid` in the same cycle.
- R10: While `rstN` is low with `PIPE`=1, `doneOut`, `resOut` and `invalidOut` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Vector present this cycle |
| selMax | input | 1 | 1 selects maximum, 0 selects minimum |
| assocMode | input | 1 | 1 selects associative mode, 0 selects pairwise mode |
| vecIn | input | 128 | Four binary32 lanes, with lane 0 in the low bits |
| resOut | output | 32 | Reduced scalar result |
| invalidOut | output | 1 | A signaling NaN was present in the vector |
| doneOut | output | 1 | `resOut` and `invalidOut` are valid |

## Verification
The hardest case to reach from the ports is a second-level stage that receives two NaN partial results. That stage must then order the quieted values by key, so the outcome rests on the payload bits rather than on the lane positions. The stimulus reaches it by mixing signaling and quiet NaNs of both signs, with different payloads, in all four lanes. Quieting is chosen so that it changes the raw order of two payloads. Each associative vector is also replayed in all 24 lane orderings, so that a signaling NaN passes through both first-level stages and both input positions of every stage.

// File: rtl/vmr_pkg.sv
package vmr_pkg;
  localparam int EXP_W = 8;
  localparam int MAN_W = 23;
  localparam int FW = EXP_W + MAN_W + 1;
  localparam int LANES = 4;
  localparam int QBIT = MAN_W - 1;

  typedef logic [FW-1:0] fp_t;

  typedef struct packed {
    logic loadMid;
    logic doneStb;
  } strobe_t;

  function automatic logic isNan(input fp_t x);
    return (&x[FW-2:MAN_W]) && (|x[MAN_W-1:0]);
  endfunction

  function automatic logic isSnan(input fp_t x);
    return isNan(x) && !x[QBIT];
  endfunction

  function automatic fp_t quietOf(input fp_t x);
    fp_t q;
    q = x;
    q[QBIT] = 1'b1;
    return q;
  endfunction

  // Sign-magnitude ordering folded into an unsigned key (-0 below +0)
  function automatic fp_t orderKey(input fp_t x);
    fp_t k;
    if (x[FW-1]) begin
      k = ~x;
    end else begin
      k = x;
      k[FW-1] = 1'b1;
    end
    return k;
  endfunction
endpackage

// File: rtl/vmr_stage.sv
module vmr_stage
  import vmr_pkg::*;
(
  input  fp_t  opA,
  input  fp_t  opB,
  input  logic pickMax,
  input  logic assoc,
  output fp_t  res
);
  logic aNan, bNan;
  fp_t qa, qb, ka, kb;
  logic takeA;

  always_comb begin
    aNan = isNan(opA);
    bNan = isNan(opB);
    qa = quietOf(opA);
    qb = quietOf(opB);
    ka = (aNan && bNan) ? orderKey(qa) : orderKey(opA);
    kb = (aNan && bNan) ? orderKey(qb) : orderKey(opB);
    takeA = pickMax ? (ka >= kb) : (ka <= kb);
    if (aNan && bNan) begin
      res = takeA ? qa : qb;
    end else if (aNan) begin
      res = (!assoc && isSnan(opA)) ? qa : opB;
    end else if (bNan) begin
      res = (!assoc && isSnan(opB)) ? qb : opA;
    end else begin
      res = takeA ? opA : opB;
    end
  end
endmodule

// File: rtl/vmr_ctrl.sv
module vmr_ctrl #(
  parameter bit PIPE = 1'b1
) (
  input  logic clk,
  input  logic rstN,
  input  logic inValid,
  output vmr_pkg::strobe_t strb
);
  logic doneQ;

  generate
    if (PIPE) begin : g_reg
      always_ff @(posedge clk) begin
        if (!rstN) doneQ <= 1'b0;
        else doneQ <= inValid;
      end
    end else begin : g_comb
      assign doneQ = inValid;
    end
  endgenerate

  assign strb.loadMid = inValid;
  assign strb.doneStb = doneQ;
endmodule

// File: rtl/vmr_datapath.sv
module vmr_datapath
  import vmr_pkg::*;
#(
  parameter bit PIPE = 1'b1
) (
  input  logic clk,
  input  logic rstN,
  input  strobe_t strb,
  input  logic [LANES*FW-1:0] vecIn,
  input  logic selMax,
  input  logic assocMode,
  output fp_t  resOut,
  output logic invalidOut
);
  localparam int PAIRS = LANES / 2;

  fp_t  part    [PAIRS];
  fp_t  midPart [PAIRS];
  logic midMax, midAssoc, midInv;
  logic snanAny;
  fp_t  finalRes;

  always_comb begin
    snanAny = 1'b0;
    for (int k = 0; k < LANES; k++) begin
      snanAny = snanAny | isSnan(vecIn[k*FW +: FW]);
    end
  end

  generate
    for (genvar g = 0; g < PAIRS; g++) begin : g_lvl1
      vmr_stage u_stage (
        .opA(vecIn[(2*g)*FW +: FW]),
        .opB(vecIn[(2*g+1)*FW +: FW]),
        .pickMax(selMax),
        .assoc(assocMode),
        .res(part[g])
      );
    end

    if (PIPE) begin : g_mid
      always_ff @(posedge clk) begin
        if (!rstN) begin
          for (int k = 0; k < PAIRS; k++) midPart[k] <= '0;
          midMax <= 1'b0;
          midAssoc <= 1'b0;
          midInv <= 1'b0;
        end else if (strb.loadMid) begin
          for (int k = 0; k < PAIRS; k++) midPart[k] <= part[k];
          midMax <= selMax;
          midAssoc <= assocMode;
          midInv <= snanAny;
        end
      end
    end else begin : g_nomid
      always_comb begin
        for (int k = 0; k < PAIRS; k++) midPart[k] = part[k];
        midMax = selMax;
        midAssoc = assocMode;
        midInv = snanAny;
      end
    end
  endgenerate

  vmr_stage u_lvl2 (
    .opA(midPart[0]),
    .opB(midPart[1]),
    .pickMax(midMax),
    .assoc(midAssoc),
    .res(finalRes)
  );

  assign resOut = finalRes;
  assign invalidOut = midInv;

  // R5
  assoc_num_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.doneStb && midAssoc && (!isNan(midPart[0]) || !isNan(midPart[1])))
      |-> !isNan(finalRes));

  // R6
  nan_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.doneStb && isNan(finalRes)) |-> finalRes[QBIT]);

  // R2
  max_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.doneStb && midMax && !isNan(midPart[0]) && !isNan(midPart[1]))
      |-> (orderKey(finalRes) >= orderKey(midPart[0])) &&
          (orderKey(finalRes) >= orderKey(midPart[1])));

  // R2
  min_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.doneStb && !midMax && !isNan(midPart[0]) && !isNan(midPart[1]))
      |-> (orderKey(finalRes) <= orderKey(midPart[0])) &&
          (orderKey(finalRes) <= orderKey(midPart[1])));
endmodule

// File: rtl/vec_minmax_reduce.sv
module vec_minmax_reduce
  import vmr_pkg::*;
#(
  parameter bit PIPE = 1'b1
) (
  input  logic clk,
  input  logic rstN,
  input  logic inValid,
  input  logic selMax,
  input  logic assocMode,
  input  logic [LANES*FW-1:0] vecIn,
  output logic [FW-1:0] resOut,
  output logic invalidOut,
  output logic doneOut
);
  strobe_t strb;

  vmr_ctrl #(.PIPE(PIPE)) u_ctrl (
    .clk(clk),
    .rstN(rstN),
    .inValid(inValid),
    .strb(strb)
  );

  vmr_datapath #(.PIPE(PIPE)) u_dp (
    .clk(clk),
    .rstN(rstN),
    .strb(strb),
    .vecIn(vecIn),
    .selMax(selMax),
    .assocMode(assocMode),
    .resOut(resOut),
    .invalidOut(invalidOut)
  );

  assign doneOut = strb.doneStb;
endmodule

// File: tb/vec_minmax_reduce_tb.sv
`timescale 1ns/1ps
module vec_minmax_reduce_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic selMax = 1'b0;
  logic assocMode = 1'b0;
  logic [127:0] vecIn = '0;
  logic [31:0] resOut;
  logic invalidOut, doneOut;
  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  vec_minmax_reduce u_dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .selMax(selMax),
    .assocMode(assocMode), .vecIn(vecIn), .resOut(resOut),
    .invalidOut(invalidOut), .doneOut(doneOut)
  );

  typedef struct packed {
    logic [127:0] vec;
    logic mx;
    logic as;
    logic [31:0] res;
    logic inv;
  } ent_t;

  localparam int NE = 16;
  localparam ent_t TAB [NE] = '{
    '{128'h7f800001_40400000_40000000_3f800000, 1'b1, 1'b0, 32'h40000000, 1'b1}, // R4 max pair
    '{128'h7f800001_40400000_40000000_3f800000, 1'b1, 1'b1, 32'h40400000, 1'b1}, // R5 max assoc
    '{128'h7f800001_3f800000_40000000_40400000, 1'b0, 1'b1, 32'h3f800000, 1'b1}, // R5 min assoc
    '{128'h7f800001_3f800000_40000000_40400000, 1'b0, 1'b0, 32'h40000000, 1'b1}, // R4 min pair
    '{128'h40000000_c0000000_40400000_bf800000, 1'b1, 1'b0, 32'h40400000, 1'b0}, // R2
    '{128'h40000000_c0000000_40400000_bf800000, 1'b0, 1'b1, 32'hc0000000, 1'b0}, // R2
    '{128'h80000000_80000000_00000000_80000000, 1'b1, 1'b1, 32'h00000000, 1'b0}, // R3
    '{128'h00000000_00000000_80000000_00000000, 1'b0, 1'b0, 32'h80000000, 1'b0}, // R3
    '{128'h7fc00000_40000000_3f800000_7fc00000, 1'b1, 1'b0, 32'h40000000, 1'b0}, // R4 qNaN missing
    '{128'h7f800001_ffc00000_7fa00000_7fc00000, 1'b1, 1'b1, 32'h7fe00000, 1'b1}, // R6
    '{128'h7f800001_ffc00000_7fa00000_7fc00000, 1'b0, 1'b1, 32'hffc00000, 1'b1}, // R6
    '{128'h7f800001_ffc00000_7fa00000_7fc00000, 1'b1, 1'b0, 32'h7fe00000, 1'b1}, // R6 pair
    '{128'h7fc00000_7fc00000_ff800000_7f800001, 1'b1, 1'b1, 32'hff800000, 1'b1}, // R5
    '{128'h7f800001_ffc00000_7f800000_7fc00000, 1'b0, 1'b1, 32'h7f800000, 1'b1}, // R5
    '{128'h40000000_7fc00000_7f800001_3f800000, 1'b0, 1'b0, 32'h40000000, 1'b1}, // R4
    '{128'h3f800000_3f800000_7fa00000_7f800001, 1'b1, 1'b0, 32'h3f800000, 1'b1}  // R6 R7
  };

  task automatic check(input bit ok, input string req, input logic [32:0] act,
                       input logic [32:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Applies one vector, checks result at done (R1, R7, R9) and done drop after
  task automatic runVec(input logic [127:0] v, input logic mx, input logic as,
                        input logic [31:0] expRes, input logic expInv, input string req);
    @(negedge clk);
    vecIn = v; selMax = mx; assocMode = as; inValid = 1'b1;
    @(negedge clk);
    check(doneOut === 1'b1, "R9 done", {32'h0, doneOut}, 33'h1);
    check({resOut, invalidOut} === {expRes, expInv}, req,
          {resOut, invalidOut}, {expRes, expInv});
    inValid = 1'b0;
    vecIn = '0;
    @(negedge clk);
    check(doneOut === 1'b0, "R9 idle", {32'h0, doneOut}, 33'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    check({resOut, invalidOut, doneOut} === 34'h0, "R10 reset",
          {resOut, invalidOut}, 33'h0);
    check(doneOut === 1'b0, "R10 done", {32'h0, doneOut}, 33'h0);
    rstN = 1'b1;
    for (int e = 0; e < NE; e++) begin
      runVec(TAB[e].vec, TAB[e].mx, TAB[e].as, TAB[e].res, TAB[e].inv, "R1 table");
    end
    // R8: every ordering of lanes in associative mode
    for (int e = 0; e < NE; e++) begin
      if (TAB[e].as) begin
        for (int a = 0; a < 4; a++)
          for (int b = 0; b < 4; b++)
            for (int c = 0; c < 4; c++)
              for (int d = 0; d < 4; d++)
                if (a != b && a != c && a != d && b != c && b != d && c != d) begin
                  logic [127:0] pv;
                  pv = {TAB[e].vec[d*32 +: 32], TAB[e].vec[c*32 +: 32],
                        TAB[e].vec[b*32 +: 32], TAB[e].vec[a*32 +: 32]};
                  runVec(pv, TAB[e].mx, TAB[e].as, TAB[e].res, TAB[e].inv, "R8 perm");
                end
      end
    end
    // R7 no signaling NaN among quiet NaNs of both signs
    runVec(128'hffc00000_7fc00000_ffc00001_7fc00002, 1'b1, 1'b0, 32'h7fc00002, 1'b0, "R7 quiet");
    // R4 signaling NaN in lane 0 with pairwise max over numbers elsewhere
    runVec(128'h40400000_40000000_3f800000_7f800001, 1'b1, 1'b0, 32'h40400000, 1'b1, "R4 lane0");
    // R10 reset again clears outputs
    @(negedge clk);
    vecIn = 128'h40400000_40000000_3f800000_3f800000; inValid = 1'b1; selMax = 1'b1;
    @(negedge clk);
    rstN = 1'b0; inValid = 1'b0;
    @(negedge clk);
    check({resOut, invalidOut, doneOut} === 34'h0, "R10 rereset",
          {resOut, invalidOut}, 33'h0);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule